// File: doc/BRIEF.md
# Battery Charge Phase Sequencer

This block is the digital sequencer of a single-string battery charger. It takes comparator flags that are already digital (battery under the low-voltage level, battery under the recharge level, charge current under the termination level, battery overvoltage, input fault), a charge-enable level, a 1 ms tick and a strap that disables the safety timers. From these it decides whether the converter runs in precharge or fast charge, or is held off in idle, done or fault.

Each comparator flag passes through its own deglitch filter. A filtered output changes only after the raw flag has disagreed with it for a set number of consecutive ticks, and this holds for both edges. Termination is a two-stage decision: a deglitched low-current flag first moves the machine into a qualification window. Only if the window completes without disturbance is the done state entered. Every duration is a count of ticks set by a parameter, so a bench can shrink it. The fast-charge limit is an input, so it can be programmed.

Top module: `chg_phase_ctrl`

## Requirements
- R1: After reset the block stays idle (phase 0, converter off) until PWRUP_T ticks have been counted. In the cycle after the PWRUP_T-th tick it leaves idle if enabled.
- R2: From idle with enable high and no input fault, the block enters precharge (phase 1, cur_mode 2'b01) if the filtered low-voltage flag is set, and fast charge (phase 2, cur_mode 2'b10) otherwise. The converter enable is high in phases 1, 2 and 3.
- R3: The low-voltage flag is deglitched by LOWV_DG ticks on both edges. Precharge moves to fast charge on the LOWV_DG-th consecutive tick with the raw flag low, and fast charge returns to precharge the same way. A shorter pulse has no effect.
- R4: In fast charge, when the termination flag has been filtered high (TERM_DG ticks) and the filtered recharge flag is low, the block enters qualification (phase 3) with the converter still on.
- R5: Qualification lasts QUAL_T ticks and then enters done (phase 4, done_o high, converter off). It goes back to fast charge if the filtered termination flag drops, the filtered recharge flag rises, the filtered low-voltage flag rises, or the timer strap is asserted.
- R6: Ticks spent in precharge are counted. When PRE_LIM ticks are reached, the block enters fault (phase 5, fault_o high, converter off).
- R7: Ticks spent in fast charge and qualification are counted together. When fast_limit_ms_i ticks are reached, the block enters fault.
- R8: While timer_dis_i is high, neither safety limit causes a fault and qualification is never entered. Fast charge continues indefinitely.
- R9: In done, the recharge flag deglitched by RECH_DG ticks returns the block to fast charge, with the fast-charge count restarted from zero.
- R10: Enable low or input fault high sends any state to idle in the next cycle and clears both safety counts.
- R11: Fault persists while enabled. It is left only by dropping enable (or raising input fault), or by a rising edge of the filtered recharge flag. After either, the precharge/fast decision is made again.
- R12: While bat_ov_i is high the converter enable is low, without a change of phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| chg_en_i | input | 1 | Charge enable |
| in_fault_i | input | 1 | Input supply fault |
| bat_low_i | input | 1 | Battery under low-voltage level |
| bat_rech_i | input | 1 | Battery under recharge level |
| cur_term_i | input | 1 | Charge current under termination level |
| bat_ov_i | input | 1 | Battery overvoltage |
| timer_dis_i | input | 1 | Strap: disable safety timers and termination |
| fast_limit_ms_i | input | LIMW | Fast-charge limit in ticks |
| chg_on_o | output | 1 | Converter enable |
| cur_mode_o | output | 2 | 01 precharge, 10 fast, 00 off |
| phase_o | output | 3 | Phase code 0..5 |
| done_o | output | 1 | Charge complete |
| fault_o | output | 1 | Safety timer fault |

## Verification
The hardest situation to reach is a fast-charge timer expiry whose count spans both fast charge and an aborted qualification window. A fault is also hard to leave through a recharge edge rather than through enable. The stimulus walks one continuous sequence. It qualifies, reaches done, recharges, re-qualifies, aborts through the recharge flag, and then runs out the remaining fast-charge budget counted tick by tick. It then lowers and raises the recharge flag past its deglitch to release the fault.

// File: rtl/chg_phase_pkg.sv
package chg_phase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_FAST  = 3'd2,
    ST_QUAL  = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } chg_state_e;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_PRE  = 2'b01;
  localparam logic [1:0] MODE_FAST = 2'b10;
endpackage

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
  parameter int unsigned DG      = 25,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (DG < 2) ? 1 : $clog2(DG + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= RST_VAL;
    end else if (raw_i == filt_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(DG - 1)) begin
        cnt_q  <= '0;
        filt_o <= raw_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_DG_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> $past(tick_i) && $past(raw_i) == filt_o); // R3

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int unsigned CW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          exp_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clr_i)                           cnt_q <= '0;
    else if (run_i && tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = (cnt_q >= limit_i);

  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_o && !clr_i && $stable(limit_i)) |=> exp_o); // R6
  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl
  import chg_phase_pkg::*;
#(
  parameter int unsigned LOWV_DG = 25,
  parameter int unsigned TERM_DG = 100,
  parameter int unsigned QUAL_T  = 250,
  parameter int unsigned RECH_DG = 10,
  parameter int unsigned PRE_LIM = 1_800_000,
  parameter int unsigned PWRUP_T = 1500,
  parameter int unsigned LIMW    = 26
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_ms_i,
  input  logic            chg_en_i,
  input  logic            in_fault_i,
  input  logic            bat_low_i,
  input  logic            bat_rech_i,
  input  logic            cur_term_i,
  input  logic            bat_ov_i,
  input  logic            timer_dis_i,
  input  logic [LIMW-1:0] fast_limit_ms_i,
  output logic            chg_on_o,
  output logic [1:0]      cur_mode_o,
  output logic [2:0]      phase_o,
  output logic            done_o,
  output logic            fault_o
);
  localparam int unsigned QW  = (QUAL_T < 2) ? 1 : $clog2(QUAL_T + 1);
  localparam int unsigned PW  = (PRE_LIM < 2) ? 1 : $clog2(PRE_LIM + 1);
  localparam int unsigned UW  = (PWRUP_T < 2) ? 1 : $clog2(PWRUP_T + 1);

  chg_state_e state_q, state_d;

  logic low_f, rech_f, term_f, rech_q, rech_rise;
  logic pwr_ok, pre_exp, fast_exp, tmr_clr;
  logic [QW-1:0] qual_q;
  logic qual_end, qual_abort;

  // Per-flag deglitch filters
  chg_deglitch #(.DG(LOWV_DG), .RST_VAL(1'b0)) u_dg_low (
    .clk_i, .rst_ni, .tick_i(tick_ms_i), .raw_i(bat_low_i), .filt_o(low_f));
  chg_deglitch #(.DG(RECH_DG), .RST_VAL(1'b0)) u_dg_rech (
    .clk_i, .rst_ni, .tick_i(tick_ms_i), .raw_i(bat_rech_i), .filt_o(rech_f));
  chg_deglitch #(.DG(TERM_DG), .RST_VAL(1'b0)) u_dg_term (
    .clk_i, .rst_ni, .tick_i(tick_ms_i), .raw_i(cur_term_i), .filt_o(term_f));

  assign tmr_clr = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAULT);

  chg_safety_timer #(.CW(UW)) u_pwrup (
    .clk_i, .rst_ni, .tick_i(tick_ms_i), .run_i(1'b1), .clr_i(1'b0),
    .limit_i(UW'(PWRUP_T)), .exp_o(pwr_ok));
  chg_safety_timer #(.CW(PW)) u_pre_tmr (
    .clk_i, .rst_ni, .tick_i(tick_ms_i), .run_i(state_q == ST_PRE), .clr_i(tmr_clr),
    .limit_i(PW'(PRE_LIM)), .exp_o(pre_exp));
  chg_safety_timer #(.CW(LIMW)) u_fast_tmr (
    .clk_i, .rst_ni, .tick_i(tick_ms_i),
    .run_i((state_q == ST_FAST) || (state_q == ST_QUAL)), .clr_i(tmr_clr),
    .limit_i(fast_limit_ms_i), .exp_o(fast_exp));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rech_q <= 1'b0;
    else         rech_q <= rech_f;
  end
  assign rech_rise = rech_f && !rech_q;

  // Qualification window counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   qual_q <= '0;
    else if (state_q != ST_QUAL)   qual_q <= '0;
    else if (tick_ms_i && !qual_end) qual_q <= qual_q + 1'b1;
  end
  assign qual_end   = tick_ms_i && (qual_q == QW'(QUAL_T - 1));
  assign qual_abort = !term_f || rech_f || low_f || timer_dis_i;

  always_comb begin
    state_d = state_q;
    if (!chg_en_i || in_fault_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (pwr_ok) state_d = low_f ? ST_PRE : ST_FAST;
        ST_PRE: begin
          if (pre_exp && !timer_dis_i) state_d = ST_FAULT;
          else if (!low_f)             state_d = ST_FAST;
        end
        ST_FAST: begin
          if (fast_exp && !timer_dis_i)             state_d = ST_FAULT;
          else if (low_f)                           state_d = ST_PRE;
          else if (term_f && !rech_f && !timer_dis_i) state_d = ST_QUAL;
        end
        ST_QUAL: begin
          if (fast_exp && !timer_dis_i) state_d = ST_FAULT;
          else if (qual_abort)          state_d = ST_FAST;
          else if (qual_end)            state_d = ST_DONE;
        end
        ST_DONE:  if (rech_f)    state_d = ST_FAST;
        ST_FAULT: if (rech_rise) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  logic active;
  assign active     = (state_q == ST_PRE) || (state_q == ST_FAST) || (state_q == ST_QUAL);
  assign chg_on_o   = active && !bat_ov_i;
  assign cur_mode_o = (state_q == ST_PRE) ? MODE_PRE : (active ? MODE_FAST : MODE_OFF);
  assign phase_o    = state_q;
  assign done_o     = (state_q == ST_DONE);
  assign fault_o    = (state_q == ST_FAULT);

  AST_HOLD_PWRUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok |-> state_q == ST_IDLE); // R1
  AST_DIS_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chg_en_i || in_fault_i) |=> state_q == ST_IDLE); // R10
  AST_DONE_VIA_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && $past(state_q) != ST_DONE) |-> $past(state_q) == ST_QUAL); // R5
  AST_NO_QUAL_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_dis_i && state_q != ST_QUAL) |=> state_q != ST_QUAL); // R8
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT && chg_en_i && !in_fault_i && rech_q) |=> state_q == ST_FAULT); // R11

endmodule

// File: tb/chg_phase_ctrl_tb_top.sv
module chg_phase_ctrl_tb_top;
  localparam int LIMW = 26;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic en = 1'b1, flt = 1'b0, low = 1'b1, rech = 1'b1, term = 1'b0, ov = 1'b0, dis = 1'b0;
  logic [LIMW-1:0] flim = LIMW'(30);
  logic chg_on, done_w, fault_w;
  logic [1:0] mode;
  logic [2:0] phase;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  chg_phase_ctrl #(.LOWV_DG(3), .TERM_DG(4), .QUAL_T(5), .RECH_DG(2),
                   .PRE_LIM(20), .PWRUP_T(6), .LIMW(LIMW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_ms_i(tick), .chg_en_i(en), .in_fault_i(flt),
    .bat_low_i(low), .bat_rech_i(rech), .cur_term_i(term), .bat_ov_i(ov),
    .timer_dis_i(dis), .fast_limit_ms_i(flim), .chg_on_o(chg_on), .cur_mode_o(mode),
    .phase_o(phase), .done_o(done_w), .fault_o(fault_w));

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int exp_ph, input bit exp_on);
    checks++;
    if (phase !== 3'(exp_ph) || chg_on !== exp_on) begin
      errors++;
      $display("FAIL %s: phase=%0d on=%0b expected phase=%0d on=%0b",
               req, phase, chg_on, exp_ph, exp_on);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset", 0, 0);
    tk(5);  chk("R1 hold", 0, 0);
    tk(1);  chk("R2 precharge", 1, 1);
    checks++; if (mode !== 2'b01) begin errors++; $display("FAIL R2: mode=%0b expected=01", mode); end
    low = 1'b0;
    tk(2);  chk("R3 rise pending", 1, 1);
    tk(1);  chk("R3 to fast", 2, 1);
    checks++; if (mode !== 2'b10) begin errors++; $display("FAIL R2: mode=%0b expected=10", mode); end
    low = 1'b1; tk(2); low = 1'b0; tk(1);
    chk("R3 glitch ignored", 2, 1);
    low = 1'b1; tk(3); chk("R3 back to pre", 1, 1);
    low = 1'b0; tk(3); chk("R3 fast again", 2, 1);
    // termination and qualification
    term = 1'b1; rech = 1'b0;
    tk(3);  chk("R4 term pending", 2, 1);
    tk(1);  chk("R4 qualify", 3, 1);
    tk(4);  chk("R5 window", 3, 1);
    tk(1);  chk("R5 done", 4, 0);
    chk_bit("R5 done_o", done_w, 1'b1);
    // recharge
    rech = 1'b1;
    tk(1);  chk("R9 pending", 4, 0);
    tk(1);  chk("R9 recharge", 2, 1);
    rech = 1'b0;
    tk(2);  chk("R4 requalify", 3, 1);
    rech = 1'b1;
    tk(1);  chk("R5 abort pending", 3, 1);
    tk(1);  chk("R5 abort", 2, 1);
    // fast timer: 4 ticks used since recharge restart
    tk(25); chk("R7 before limit", 2, 1);
    tk(1);  chk("R7 fault", 5, 0);
    chk_bit("R7 fault_o", fault_w, 1'b1);
    tk(5);  chk("R11 sticky", 5, 0);
    rech = 1'b0; tk(2); chk("R11 sticky low", 5, 0);
    rech = 1'b1; tk(2); cyc(1); chk("R11 rech edge exit", 2, 1);
    en = 1'b0; cyc(1); chk("R10 disable", 0, 0);
    low = 1'b1; tk(3);
    en = 1'b1; cyc(1); chk("R2 pre decision", 1, 1);
    tk(19); chk("R6 before limit", 1, 1);
    tk(1);  chk("R6 fault", 5, 0);
    en = 1'b0; cyc(1); chk("R11 enable drop", 0, 0);
    en = 1'b1; cyc(1); chk("R11 restart", 1, 1);
    tk(19); chk("R10 timer cleared", 1, 1);
    flt = 1'b1; cyc(1); chk("R10 input fault", 0, 0);
    flt = 1'b0; cyc(1); chk("R10 resume", 1, 1);
    ov = 1'b1; cyc(1); chk("R12 ov off", 1, 0);
    ov = 1'b0; cyc(1); chk("R12 ov release", 1, 1);
    dis = 1'b1;
    tk(30); chk("R8 no pre fault", 1, 1);
    low = 1'b0; tk(3); chk("R8 fast", 2, 1);
    rech = 1'b0; tk(40); chk("R8 no term no fault", 2, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule